// File: doc/BRIEF.md
# Clock Frequency Measurement Counter

This block measures how fast a test clock runs by counting its edges during a window of a known number of reference-clock ticks. The reference-domain side holds a window counter loaded from a control word. The test-domain side counts test edges while the window is open. When the window closes, the reference side waits out a settle interval and then captures the count. It raises a done flag and holds the captured count, together with an overflow bit, in a status word until the next stop write.

Software may drive the control word directly. It writes a stop word with the enable clear, waits until done reads low, writes the start word with the enable set, waits for done, reads the status and stops again. A built-in sequencer can run the same handshake by itself instead. It first runs a short window and then a long one, and reports the long count. The test counter can only clear on a test edge, so a stopped test clock leaves the same count in both windows. The sequencer reports equal counts as a stopped clock with a count of zero. Conversion of the count to Hz is done downstream.

Top module: `freq_meter`

## Requirements
- R1: After reset the status word is all zero, the sequencer is not busy and its result pulse is low.
- R2: The control word carries the tick count in bits TICK_W-1:0 and the enable in bit EN_BIT (20 by default). A start write in the idle state opens a window of exactly that many reference cycles. The captured count is within 3 of ticks × Tref / Ttest.
- R3: A write with the enable clear stops the window and drops done on the next cycle. A start write made while a window is running or done is showing is ignored.
- R4: Done rises once the window and the settle interval have passed. While done is high and nothing is written, the captured count and overflow do not change.
- R5: Status word layout: captured count in bits CNT_W-1:0, done in bit CNT_W (25 by default), overflow in bit CNT_W+1.
- R6: With the test clock stopped, a new measurement returns exactly the count of the previous one, because the counter cannot clear without test edges.
- R7: The test counter saturates at all ones instead of wrapping, and the overflow bit is then set. The next window clears the overflow.
- R8: A one-cycle sequencer start runs a short window of SHORT_TICKS and then a long window of LONG_TICKS. It reports the long-window count.
- R9: When the short and long counts are equal, the sequencer sets its clock-off flag and reports a count of zero.
- R10: While the sequencer is busy, a start request and any direct control write are ignored.
- R11: The sequencer's result pulse lasts one cycle and comes on the same edge on which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| tst_clk | input | 1 | Clock under measurement |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | EN_BIT+1 | Control word: ticks and enable |
| stat_word | output | CNT_W+2 | Status word: overflow, done, count |
| seq_start | input | 1 | Sequencer start pulse |
| seq_busy | output | 1 | Sequencer running |
| seq_done | output | 1 | One-cycle result pulse |
| seq_count | output | CNT_W | Long-window count, zero when clock is off |
| seq_clk_off | output | 1 | Short and long counts were equal |
| seq_ovf | output | 1 | Long window saturated |

## Verification
The bench stops the test clock between measurements. A design that cleared the count on a stop write, or only on a reference event, would then return zero instead of the old value, and it would never flag the stopped clock. A saturation case runs a fast clock over a long window. A wrapping counter would give a small wrong count, and an overflow that never clears would show up in the next measurement. A stray direct write and a second start pulse are injected during a sequencer run. A sequencer that let them through would cut off its long window or run a second time.

// File: rtl/fm_pkg.sv
package fm_pkg;
   typedef enum logic [1:0] {
      WIN_IDLE   = 2'd0,
      WIN_RUN    = 2'd1,
      WIN_SETTLE = 2'd2,
      WIN_DONE   = 2'd3
   } win_state_e;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_STOP  = 3'd1,
      SQ_WLO   = 3'd2,
      SQ_RUN   = 3'd3,
      SQ_WHI   = 3'd4,
      SQ_FIN   = 3'd5
   } seq_state_e;
endpackage

// File: rtl/fm_tst_cnt.sv
module fm_tst_cnt #(
   parameter int CNT_W       = 25,
   parameter int SYNC_STAGES = 2
) (
   input  logic             tst_clk,
   input  logic             rst_n,
   input  logic             gate_in,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   g_s;
   logic                   g_d;

   // synchronizer chain, one flop per stage
   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge tst_clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= gate_in;
         end else begin : g_next
            always_ff @(posedge tst_clk or negedge rst_n)
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
         end
      end
   endgenerate

   assign g_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge tst_clk or negedge rst_n) begin
      if (!rst_n) begin
         g_d <= 1'b0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         g_d <= g_s;
         if (g_s && !g_d) begin
            cnt <= '0;
            ovf <= 1'b0;
         end else if (g_s) begin
            if (cnt == '1) ovf <= 1'b1;
            else           cnt <= cnt + 1'b1;
         end
      end
   end

   // closed window: count frozen
   assert_hold_closed_R6: assert property (@(posedge tst_clk) disable iff (!rst_n)
      !g_s |=> $stable(cnt));
   // saturated counter stays at all ones inside the window
   assert_sat_hold_R7: assert property (@(posedge tst_clk) disable iff (!rst_n)
      (cnt == '1 && g_s && g_d) |=> (cnt == '1 && ovf));
endmodule

// File: rtl/fm_ref_ctrl.sv
module fm_ref_ctrl
   import fm_pkg::*;
#(
   parameter int TICK_W     = 20,
   parameter int CNT_W      = 25,
   parameter int SETTLE_CYC = 16
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              wr_en,
   input  logic [TICK_W-1:0] wr_ticks,
   input  logic [CNT_W-1:0]  tst_cnt,
   input  logic              tst_ovf,
   output logic              gate_q,
   output logic              done,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              ovf_q
);
   localparam int SET_W = $clog2(SETTLE_CYC + 1);

   win_state_e        st;
   logic [TICK_W-1:0] rem;
   logic [SET_W-1:0]  set_cnt;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= WIN_IDLE;
         rem     <= '0;
         set_cnt <= '0;
         gate_q  <= 1'b0;
         cnt_q   <= '0;
         ovf_q   <= 1'b0;
      end else if (wr && !wr_en) begin
         st     <= WIN_IDLE;
         rem    <= wr_ticks;
         gate_q <= 1'b0;
      end else if (wr && wr_en && st == WIN_IDLE) begin
         if (wr_ticks == '0) begin
            st      <= WIN_SETTLE;
            set_cnt <= SET_W'(SETTLE_CYC);
         end else begin
            st     <= WIN_RUN;
            rem    <= wr_ticks;
            gate_q <= 1'b1;
         end
      end else begin
         case (st)
            WIN_RUN: begin
               rem <= rem - 1'b1;
               if (rem == TICK_W'(1)) begin
                  st      <= WIN_SETTLE;
                  gate_q  <= 1'b0;
                  set_cnt <= SET_W'(SETTLE_CYC);
               end
            end
            WIN_SETTLE: begin
               if (set_cnt == '0) begin
                  cnt_q <= tst_cnt;
                  ovf_q <= tst_ovf;
                  st    <= WIN_DONE;
               end else begin
                  set_cnt <= set_cnt - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign done = (st == WIN_DONE);

   // window opens only on a start write
   assert_gate_open_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(gate_q) |-> $past(wr && wr_en));
   // done holds the captured result until a write
   assert_done_hold_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (done && !wr) |=> (done && $stable(cnt_q) && $stable(ovf_q)));
endmodule

// File: rtl/fm_seq.sv
module fm_seq
   import fm_pkg::*;
#(
   parameter int TICK_W      = 20,
   parameter int CNT_W       = 25,
   parameter int EN_BIT      = 20,
   parameter int SHORT_TICKS = 4096,
   parameter int LONG_TICKS  = 65536
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              core_done,
   input  logic [CNT_W-1:0]  core_cnt,
   input  logic              core_ovf,
   output logic              busy,
   output logic              wr,
   output logic              wr_en,
   output logic [TICK_W-1:0] wr_ticks,
   output logic              res_done,
   output logic [CNT_W-1:0]  res_cnt,
   output logic              res_clk_off,
   output logic              res_ovf
);
   seq_state_e       st;
   logic             phase_long;
   logic [CNT_W-1:0] short_q;
   logic [TICK_W-1:0] cur_ticks;

   assign cur_ticks = phase_long ? TICK_W'(LONG_TICKS) : TICK_W'(SHORT_TICKS);

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SQ_IDLE;
         phase_long  <= 1'b0;
         short_q     <= '0;
         busy        <= 1'b0;
         wr          <= 1'b0;
         wr_en       <= 1'b0;
         wr_ticks    <= '0;
         res_done    <= 1'b0;
         res_cnt     <= '0;
         res_clk_off <= 1'b0;
         res_ovf     <= 1'b0;
      end else begin
         wr       <= 1'b0;
         res_done <= 1'b0;
         case (st)
            SQ_IDLE: if (start) begin
               busy       <= 1'b1;
               phase_long <= 1'b0;
               st         <= SQ_STOP;
            end
            SQ_STOP: begin
               wr       <= 1'b1;
               wr_en    <= 1'b0;
               wr_ticks <= cur_ticks;
               st       <= SQ_WLO;
            end
            SQ_WLO: if (!core_done) st <= SQ_RUN;
            SQ_RUN: begin
               wr       <= 1'b1;
               wr_en    <= 1'b1;
               wr_ticks <= cur_ticks;
               st       <= SQ_WHI;
            end
            SQ_WHI: if (core_done) begin
               if (!phase_long) begin
                  short_q    <= core_cnt;
                  phase_long <= 1'b1;
                  st         <= SQ_STOP;
               end else begin
                  res_clk_off <= (core_cnt == short_q);
                  res_cnt     <= (core_cnt == short_q) ? '0 : core_cnt;
                  res_ovf     <= (core_cnt == short_q) ? 1'b0 : core_ovf;
                  st          <= SQ_FIN;
               end
            end
            SQ_FIN: begin
               wr       <= 1'b1;
               wr_en    <= 1'b0;
               busy     <= 1'b0;
               res_done <= 1'b1;
               st       <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   // result pulse coincides with the end of busy
   assert_done_on_fall_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(busy) |-> res_done);
   assert_done_single_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
      res_done |=> !res_done);
   // clock-off result carries no count
   assert_off_zero_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (res_done && res_clk_off) |-> (res_cnt == '0));
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
   parameter int TICK_W      = 20,
   parameter int EN_BIT      = 20,
   parameter int CNT_W       = 25,
   parameter int SETTLE_CYC  = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SHORT_TICKS = 4096,
   parameter int LONG_TICKS  = 65536
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             tst_clk,
   input  logic             ctl_wr,
   input  logic [EN_BIT:0]  ctl_word,
   output logic [CNT_W+1:0] stat_word,
   input  logic             seq_start,
   output logic             seq_busy,
   output logic             seq_done,
   output logic [CNT_W-1:0] seq_count,
   output logic             seq_clk_off,
   output logic             seq_ovf
);
   localparam int MAX_TICKS = (1 << TICK_W) - 1;

   generate
      if (TICK_W > EN_BIT) begin : g_bad_tick
         $error("tick field overlaps the enable bit");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs two or more stages");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("count width too small");
      end
      if (SHORT_TICKS < 1 || LONG_TICKS <= SHORT_TICKS || LONG_TICKS > MAX_TICKS) begin : g_bad_win
         $error("window lengths out of range");
      end
   endgenerate

   logic              sq_wr, sq_en;
   logic [TICK_W-1:0] sq_ticks;
   logic              c_wr, c_en;
   logic [TICK_W-1:0] c_ticks;
   logic              gate;
   logic              c_done;
   logic [CNT_W-1:0]  c_cnt;
   logic              c_ovf;
   logic [CNT_W-1:0]  t_cnt;
   logic              t_ovf;

   // sequencer owns the control port while busy and for its final stop write
   assign c_wr    = sq_wr | (ctl_wr & ~seq_busy);
   assign c_en    = sq_wr ? sq_en    : ctl_word[EN_BIT];
   assign c_ticks = sq_wr ? sq_ticks : ctl_word[TICK_W-1:0];

   fm_ref_ctrl #(.TICK_W(TICK_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_ref (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .wr      (c_wr),
      .wr_en   (c_en),
      .wr_ticks(c_ticks),
      .tst_cnt (t_cnt),
      .tst_ovf (t_ovf),
      .gate_q  (gate),
      .done    (c_done),
      .cnt_q   (c_cnt),
      .ovf_q   (c_ovf)
   );

   fm_tst_cnt #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_tst (
      .tst_clk(tst_clk),
      .rst_n  (rst_n),
      .gate_in(gate),
      .cnt    (t_cnt),
      .ovf    (t_ovf)
   );

   fm_seq #(.TICK_W(TICK_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT),
            .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_seq (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .start      (seq_start),
      .core_done  (c_done),
      .core_cnt   (c_cnt),
      .core_ovf   (c_ovf),
      .busy       (seq_busy),
      .wr         (sq_wr),
      .wr_en      (sq_en),
      .wr_ticks   (sq_ticks),
      .res_done   (seq_done),
      .res_cnt    (seq_count),
      .res_clk_off(seq_clk_off),
      .res_ovf    (seq_ovf)
   );

   assign stat_word = {c_ovf, c_done, c_cnt};

   // direct writes never reach the core while the sequencer runs
   assert_busy_blocks_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (seq_busy && !sq_wr) |-> !c_wr);
endmodule

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
   localparam int CNT_W  = 10;
   localparam int EN_BIT = 20;
   localparam int SHORT  = 40;
   localparam int LONG   = 300;
   localparam int TREF   = 20;

   logic             ref_clk = 1'b0;
   logic             tst_clk = 1'b0;
   logic             rst_n   = 1'b0;
   logic             ctl_wr  = 1'b0;
   logic [EN_BIT:0]  ctl_word = '0;
   logic [CNT_W+1:0] stat_word;
   logic             seq_start = 1'b0;
   logic             seq_busy, seq_done, seq_clk_off, seq_ovf;
   logic [CNT_W-1:0] seq_count;

   int  checks = 0;
   int  failures = 0;
   int  thalf = 5;
   bit  trun = 1'b1;

   freq_meter #(.CNT_W(CNT_W), .EN_BIT(EN_BIT), .TICK_W(20), .SETTLE_CYC(16),
                .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) dut_i (
      .ref_clk(ref_clk), .rst_n(rst_n), .tst_clk(tst_clk),
      .ctl_wr(ctl_wr), .ctl_word(ctl_word), .stat_word(stat_word),
      .seq_start(seq_start), .seq_busy(seq_busy), .seq_done(seq_done),
      .seq_count(seq_count), .seq_clk_off(seq_clk_off), .seq_ovf(seq_ovf)
   );

   always #10 ref_clk = ~ref_clk;
   always begin
      if (trun) begin #(thalf) tst_clk = ~tst_clk; end
      else #1;
   end

   function automatic int exp_cnt(input int ticks, input int half);
      return (ticks * TREF) / (2 * half);
   endfunction

   function automatic bit near(input int act, input int exp);
      return (act >= exp - 3) && (act <= exp + 3);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_ctl(input bit en, input int ticks);
      ctl_word = '0;
      ctl_word[EN_BIT] = en;
      ctl_word[19:0] = ticks[19:0];
      ctl_wr = 1'b1;
      @(negedge ref_clk);
      ctl_wr = 1'b0;
   endtask

   task automatic measure(input int ticks, output int cnt, output bit ovf, output bit ok);
      write_ctl(1'b0, ticks);
      @(negedge ref_clk);
      write_ctl(1'b1, ticks);
      ok = 1'b0;
      for (int k = 0; k < ticks + 200; k++) begin
         if (stat_word[CNT_W]) begin ok = 1'b1; break; end
         @(negedge ref_clk);
      end
      cnt = int'(stat_word[CNT_W-1:0]);
      ovf = stat_word[CNT_W+1];
   endtask

   task automatic run_seq(input bit inject, output int cnt, output bit off, output bit ok);
      seq_start = 1'b1;
      @(negedge ref_clk);
      seq_start = 1'b0;
      ok = 1'b0;
      for (int k = 0; k < 2000; k++) begin
         if (inject && k == 100) begin
            ctl_word = '0; ctl_wr = 1'b1; seq_start = 1'b1;
         end else begin
            ctl_wr = 1'b0; seq_start = 1'b0;
         end
         if (seq_done) begin ok = 1'b1; break; end
         @(negedge ref_clk);
      end
      ctl_wr = 1'b0; seq_start = 1'b0;
      cnt = int'(seq_count);
      off = seq_clk_off;
   endtask

   initial begin
      repeat (190000) @(posedge ref_clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int  c, c_prev, seed;
      bit  o, ok, off;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge ref_clk);
      rst_n = 1'b1;
      @(negedge ref_clk);
      // R1 reset state
      chk(stat_word == '0, "R1 status", int'(stat_word), 0);
      chk(!seq_busy && !seq_done, "R1 seq idle", int'(seq_busy), 0);

      // R2 random windows and test periods
      for (int i = 0; i < 6; i++) begin
         int tk;
         thalf = 4 + int'($urandom % 17);
         tk = 20 + int'($urandom % 181);
         repeat (4) @(negedge ref_clk);
         measure(tk, c, o, ok);
         chk(ok && near(c, exp_cnt(tk, thalf)), "R2 count", c, exp_cnt(tk, thalf));
      end
      // directed: short window with fast clock
      thalf = 4;
      measure(25, c, o, ok);
      chk(ok && near(c, exp_cnt(25, 4)), "R2 short window", c, exp_cnt(25, 4));

      // R5 layout: done at bit CNT_W, overflow at CNT_W+1 low
      chk(stat_word[CNT_W] == 1'b1 && stat_word[CNT_W+1] == 1'b0, "R5 layout",
          int'(stat_word[CNT_W+1:CNT_W]), 1);
      // R4 result stable while done
      c_prev = c;
      repeat (20) @(negedge ref_clk);
      chk(stat_word[CNT_W] && int'(stat_word[CNT_W-1:0]) == c_prev, "R4 hold",
          int'(stat_word[CNT_W-1:0]), c_prev);
      // R3 start while done is ignored
      write_ctl(1'b1, 5);
      repeat (30) @(negedge ref_clk);
      chk(stat_word[CNT_W] && int'(stat_word[CNT_W-1:0]) == c_prev, "R3 start ignored",
          int'(stat_word[CNT_W-1:0]), c_prev);
      // R3 stop write drops done
      write_ctl(1'b0, 5);
      chk(stat_word[CNT_W] == 1'b0, "R3 stop clears done", int'(stat_word[CNT_W]), 0);

      // R7 saturation then clear
      thalf = 2;
      measure(1000, c, o, ok);
      chk(ok && c == (1 << CNT_W) - 1, "R7 saturate", c, (1 << CNT_W) - 1);
      chk(o == 1'b1, "R7 overflow set", int'(o), 1);
      thalf = 6;
      measure(60, c, o, ok);
      chk(o == 1'b0 && near(c, exp_cnt(60, 6)), "R7 overflow cleared", int'(o), 0);

      // R8 sequencer reports long count, R11 pulse shape
      thalf = 5;
      repeat (4) @(negedge ref_clk);
      run_seq(1'b0, c, off, ok);
      chk(ok && !off && near(c, exp_cnt(LONG, 5)), "R8 long count", c, exp_cnt(LONG, 5));
      chk(!seq_busy, "R11 busy falls with pulse", int'(seq_busy), 0);
      @(negedge ref_clk);
      chk(!seq_done, "R11 single pulse", int'(seq_done), 0);

      // R10 injected write and start during a run
      thalf = 7;
      repeat (4) @(negedge ref_clk);
      run_seq(1'b1, c, off, ok);
      chk(ok && !off && near(c, exp_cnt(LONG, 7)), "R10 writes ignored", c, exp_cnt(LONG, 7));
      repeat (30) @(negedge ref_clk);
      chk(!seq_busy, "R10 start ignored", int'(seq_busy), 0);

      // R6 stopped clock keeps the old count
      measure(80, c_prev, o, ok);
      trun = 1'b0;
      repeat (4) @(negedge ref_clk);
      measure(120, c, o, ok);
      chk(ok && c == c_prev, "R6 stopped count", c, c_prev);
      // R9 sequencer flags the stopped clock
      run_seq(1'b0, c, off, ok);
      chk(ok && off, "R9 clock off flag", int'(off), 1);
      chk(c == 0, "R9 zero count", c, 0);
      // R9 restart clears the flag
      trun = 1'b1;
      thalf = 4;
      repeat (10) @(negedge ref_clk);
      run_seq(1'b0, c, off, ok);
      chk(ok && !off && near(c, exp_cnt(LONG, 4)), "R9 running again", c, exp_cnt(LONG, 4));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule